// File: doc/BRIEF.md
# Packed Sub-Word Element Register File

This block holds 128 general-purpose 64-bit registers and lets the datapath reach them either as whole registers or as a flat, linear array of smaller elements. Each access names a starting register, an element number and an element size of 8, 16, 32 or 64 bits. Together these give a linear byte position in the storage, which is treated like a little-endian byte-addressable memory. Element 0 occupies the lowest bits of the starting register. Later elements move upward through that register and then carry on from the bottom of the next register up. They do not wrap back inside the same register.

There is one write port and two independent read ports. A write alters only the byte lanes covered by the element, through per-byte enables, so the neighbouring bytes need no read-modify-write. Reads return the element shifted down to bit 0, with the upper bits filled with zeros. Any access that would land beyond the last register is reported on an error output. Such a write is dropped, and such a read returns zero.

Top module: `elw_regfile`

## Requirements
- R1: The element size code selects the element width: 0 means 8 bits, 1 means 16 bits, 2 means 32 bits and 3 means 64 bits. A 64-bit register therefore holds 8, 4, 2 or 1 elements.
- R2: The byte position is (starting register × 8) + (element number × element bytes). The target register is that position divided by 8, and the lowest byte lane is the position modulo 8. Element 0 of a register sits at bits [width-1:0].
- R3: When an element number runs past the end of the starting register, the access continues at bit 0 of the next higher register. For example, with 16-bit elements and starting register 1, element 4 is register 2 bits 15:0.
- R4: A write changes only the bytes of the addressed element. Every other byte of that register, and every other register, keeps its value.
- R5: Read data is the addressed element moved down to bit 0, with every bit above the element width zero.
- R6: When the computed register number exceeds 127, the port's error output is 1. An erroneous write changes no storage, and an erroneous read returns zero.
- R7: A read made in the same cycle as a write to the same bytes returns the contents from before the write. The new value is visible in the cycle after the write edge.
- R8: An active-low reset clears every register to zero.
- R9: The two read ports are independent and can read different elements in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, clears storage |
| wr_en | input | 1 | Write request |
| wr_base | input | 7 | Write starting register |
| wr_idx | input | 10 | Write element number |
| wr_ew | input | 2 | Write element size code |
| wr_data | input | 64 | Write element, right-aligned; bits above the width are ignored |
| wr_err | output | 1 | Write target beyond last register |
| rd0_base | input | 7 | Read port 0 starting register |
| rd0_idx | input | 10 | Read port 0 element number |
| rd0_ew | input | 2 | Read port 0 element size code |
| rd0_data | output | 64 | Read port 0 element, zero-extended |
| rd0_err | output | 1 | Read port 0 target beyond last register |
| rd1_base | input | 7 | Read port 1 starting register |
| rd1_idx | input | 10 | Read port 1 element number |
| rd1_ew | input | 2 | Read port 1 element size code |
| rd1_data | output | 64 | Read port 1 element, zero-extended |
| rd1_err | output | 1 | Read port 1 target beyond last register |

## Verification
The properties assume that the read-port inputs used to check a write are set up in the cycle after the write. They also assume that those inputs hold steady across an edge when a property tests that a register was left untouched. The stimulus meets both assumptions: it changes every input only on the falling clock edge, and it always samples read results in a cycle after any write it depends on. The stimulus also keeps the size code within 0 to 3. It reaches the out-of-range case only through large element numbers at the top register, so the error path is tested on real wrap-around arithmetic.

// File: rtl/elw_pkg.sv
package elw_pkg;
   localparam int ELW_EW_W = 2;

   typedef enum logic [ELW_EW_W-1:0] {
      ELW_W8  = 2'd0,
      ELW_W16 = 2'd1,
      ELW_W32 = 2'd2,
      ELW_W64 = 2'd3
   } elw_width_e;

   // number of bytes an element of the given size code spans
   function automatic int elw_bytes(logic [ELW_EW_W-1:0] ew);
      return 1 << ew;
   endfunction
endpackage

// File: rtl/elw_addr_gen.sv
module elw_addr_gen
   import elw_pkg::*;
#(
   parameter int NREGS = 128,
   parameter int IDX_W = 10,
   parameter int XLEN  = 64
) (
   input  logic [$clog2(NREGS)-1:0]     base,
   input  logic [IDX_W-1:0]             idx,
   input  logic [ELW_EW_W-1:0]          ew,
   output logic [$clog2(NREGS)-1:0]     reg_no,
   output logic [$clog2(XLEN/8)-1:0]    lane,
   output logic                         err
);
   localparam int NB     = XLEN / 8;
   localparam int LANE_W = $clog2(NB);
   localparam int BASE_W = $clog2(NREGS);
   localparam int BA_W   = ((BASE_W > IDX_W) ? BASE_W : IDX_W) + LANE_W + 1;
   localparam int RN_W   = BA_W - LANE_W;

   logic [BA_W-1:0] byte_pos;
   logic [RN_W-1:0] reg_full;

   always_comb begin
      byte_pos = (BA_W'(base) << LANE_W) + (BA_W'(idx) << ew);
      reg_full = byte_pos[BA_W-1:LANE_W];
   end

   assign lane   = byte_pos[LANE_W-1:0];
   assign reg_no = reg_full[BASE_W-1:0];
   assign err    = (reg_full >= RN_W'(NREGS)) || (int'(ew) > LANE_W);
endmodule

// File: rtl/elw_byte_mask.sv
module elw_byte_mask
   import elw_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [$clog2(XLEN/8)-1:0] lane,
   input  logic [ELW_EW_W-1:0]       ew,
   output logic [XLEN/8-1:0]         mask
);
   localparam int NB = XLEN / 8;

   always_comb begin
      for (int b = 0; b < NB; b++) begin
         mask[b] = (b >= int'(lane)) && (b < int'(lane) + elw_bytes(ew));
      end
   end
endmodule

// File: rtl/elw_wr_steer.sv
module elw_wr_steer #(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0]           din,
   input  logic [$clog2(XLEN/8)-1:0] lane,
   output logic [XLEN-1:0]           dout
);
   assign dout = din << {lane, 3'b000};
endmodule

// File: rtl/elw_rd_extract.sv
module elw_rd_extract
   import elw_pkg::*;
#(
   parameter int XLEN = 64
) (
   input  logic [XLEN-1:0]           word,
   input  logic [$clog2(XLEN/8)-1:0] lane,
   input  logic [ELW_EW_W-1:0]       ew,
   input  logic                      err,
   output logic [XLEN-1:0]           dout
);
   localparam int NB = XLEN / 8;

   logic [XLEN-1:0] shifted;

   always_comb begin
      shifted = word >> {lane, 3'b000};
      for (int b = 0; b < NB; b++) begin
         dout[b*8 +: 8] = (!err && (b < elw_bytes(ew))) ? shifted[b*8 +: 8] : 8'h00;
      end
   end
endmodule

// File: rtl/elw_regfile.sv
module elw_regfile
   import elw_pkg::*;
#(
   parameter int NREGS = 128,
   parameter int IDX_W = 10,
   parameter int XLEN  = 64
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [$clog2(NREGS)-1:0]   wr_base,
   input  logic [IDX_W-1:0]           wr_idx,
   input  logic [ELW_EW_W-1:0]        wr_ew,
   input  logic [XLEN-1:0]            wr_data,
   output logic                       wr_err,
   input  logic [$clog2(NREGS)-1:0]   rd0_base,
   input  logic [IDX_W-1:0]           rd0_idx,
   input  logic [ELW_EW_W-1:0]        rd0_ew,
   output logic [XLEN-1:0]            rd0_data,
   output logic                       rd0_err,
   input  logic [$clog2(NREGS)-1:0]   rd1_base,
   input  logic [IDX_W-1:0]           rd1_idx,
   input  logic [ELW_EW_W-1:0]        rd1_ew,
   output logic [XLEN-1:0]            rd1_data,
   output logic                       rd1_err
);
   localparam int NB     = XLEN / 8;
   localparam int LANE_W = $clog2(NB);
   localparam int BASE_W = $clog2(NREGS);
   localparam int NRD    = 2;

   generate
      if (XLEN < 16 || XLEN > 64 || (XLEN & (XLEN - 1)) != 0) begin : g_bad_xlen
         $error("elw_regfile: XLEN must be a power of two between 16 and 64");
      end
      if (NREGS < 2) begin : g_bad_nregs
         $error("elw_regfile: NREGS must be at least 2");
      end
      if (IDX_W < 1) begin : g_bad_idx
         $error("elw_regfile: IDX_W must be at least 1");
      end
   endgenerate

   logic [XLEN-1:0] regs [NREGS];

   // write path
   logic [BASE_W-1:0] w_reg;
   logic [LANE_W-1:0] w_lane;
   logic [NB-1:0]     w_mask;
   logic [XLEN-1:0]   w_steered;

   elw_addr_gen #(.NREGS(NREGS), .IDX_W(IDX_W), .XLEN(XLEN)) u_waddr (
      .base(wr_base), .idx(wr_idx), .ew(wr_ew),
      .reg_no(w_reg), .lane(w_lane), .err(wr_err)
   );

   elw_byte_mask #(.XLEN(XLEN)) u_wmask (
      .lane(w_lane), .ew(wr_ew), .mask(w_mask)
   );

   elw_wr_steer #(.XLEN(XLEN)) u_wsteer (
      .din(wr_data), .lane(w_lane), .dout(w_steered)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int r = 0; r < NREGS; r++) begin
            regs[r] <= '0;
         end
      end else if (wr_en && !wr_err) begin
         for (int b = 0; b < NB; b++) begin
            if (w_mask[b]) begin
               regs[w_reg][b*8 +: 8] <= w_steered[b*8 +: 8];
            end
         end
      end
   end

   // read paths
   logic [BASE_W-1:0]     rp_base [NRD];
   logic [IDX_W-1:0]      rp_idx  [NRD];
   logic [ELW_EW_W-1:0]   rp_ew   [NRD];
   logic [XLEN-1:0]       rp_data [NRD];
   logic                  rp_err  [NRD];

   assign rp_base[0] = rd0_base;
   assign rp_idx[0]  = rd0_idx;
   assign rp_ew[0]   = rd0_ew;
   assign rp_base[1] = rd1_base;
   assign rp_idx[1]  = rd1_idx;
   assign rp_ew[1]   = rd1_ew;

   generate
      for (genvar p = 0; p < NRD; p++) begin : g_rport
         logic [BASE_W-1:0] r_reg;
         logic [LANE_W-1:0] r_lane;
         logic [XLEN-1:0]   r_word;

         elw_addr_gen #(.NREGS(NREGS), .IDX_W(IDX_W), .XLEN(XLEN)) u_raddr (
            .base(rp_base[p]), .idx(rp_idx[p]), .ew(rp_ew[p]),
            .reg_no(r_reg), .lane(r_lane), .err(rp_err[p])
         );

         assign r_word = rp_err[p] ? '0 : regs[r_reg];

         elw_rd_extract #(.XLEN(XLEN)) u_rext (
            .word(r_word), .lane(r_lane), .ew(rp_ew[p]),
            .err(rp_err[p]), .dout(rp_data[p])
         );
      end
   endgenerate

   assign rd0_data = rp_data[0];
   assign rd0_err  = rp_err[0];
   assign rd1_data = rp_data[1];
   assign rd1_err  = rp_err[1];
endmodule

// File: rtl/elw_regfile_chk.sv
module elw_regfile_chk #(
   parameter int NREGS = 128,
   parameter int IDX_W = 10,
   parameter int XLEN  = 64
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic [$clog2(NREGS)-1:0] wr_base,
   input logic [IDX_W-1:0]         wr_idx,
   input logic [1:0]               wr_ew,
   input logic [XLEN-1:0]          wr_data,
   input logic                     wr_err,
   input logic [$clog2(NREGS)-1:0] rd0_base,
   input logic [IDX_W-1:0]         rd0_idx,
   input logic [1:0]               rd0_ew,
   input logic [XLEN-1:0]          rd0_data,
   input logic                     rd0_err,
   input logic [$clog2(NREGS)-1:0] rd1_base,
   input logic [IDX_W-1:0]         rd1_idx,
   input logic [1:0]               rd1_ew,
   input logic [XLEN-1:0]          rd1_data,
   input logic                     rd1_err
);
   localparam int NB = XLEN / 8;

   function automatic logic [XLEN-1:0] width_mask(logic [1:0] ew);
      logic [XLEN-1:0] m;
      for (int b = 0; b < NB; b++) begin
         m[b*8 +: 8] = (b < (1 << ew)) ? 8'hFF : 8'h00;
      end
      return m;
   endfunction

   function automatic int reg_of(int base, int idx, logic [1:0] ew);
      return (base * NB + (idx << ew)) / NB;
   endfunction

   AST_RD0_ZERO_EXT_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (!rd0_err && rd0_ew == 2'd0) |-> (rd0_data[XLEN-1:8] == '0)); // R5

   AST_RD1_ERR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      rd1_err |-> (rd1_data == '0)); // R6

   AST_WRITE_VISIBLE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_err) ##1 (rd0_base == $past(wr_base) && rd0_idx == $past(wr_idx)
                              && rd0_ew == $past(wr_ew))
      |-> (rd0_data == ($past(wr_data) & width_mask($past(wr_ew))))); // R7

   AST_ERR_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_err) ##1 ($stable(rd1_base) && $stable(rd1_idx) && $stable(rd1_ew))
      |-> $stable(rd1_data)); // R6

   AST_OTHER_REG_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !rd1_err && reg_of(int'(rd1_base), int'(rd1_idx), rd1_ew)
                            != reg_of(int'(wr_base), int'(wr_idx), wr_ew))
      ##1 ($stable(rd1_base) && $stable(rd1_idx) && $stable(rd1_ew))
      |-> $stable(rd1_data)); // R4
endmodule

bind elw_regfile elw_regfile_chk #(.NREGS(NREGS), .IDX_W(IDX_W), .XLEN(XLEN)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_base(wr_base), .wr_idx(wr_idx),
   .wr_ew(wr_ew), .wr_data(wr_data), .wr_err(wr_err),
   .rd0_base(rd0_base), .rd0_idx(rd0_idx), .rd0_ew(rd0_ew), .rd0_data(rd0_data),
   .rd0_err(rd0_err), .rd1_base(rd1_base), .rd1_idx(rd1_idx), .rd1_ew(rd1_ew),
   .rd1_data(rd1_data), .rd1_err(rd1_err)
);

// File: tb/sim_elw_regfile.sv
module sim_elw_regfile;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_en;
   logic [6:0]  wr_base;
   logic [9:0]  wr_idx;
   logic [1:0]  wr_ew;
   logic [63:0] wr_data;
   logic        wr_err;
   logic [6:0]  rd0_base;
   logic [9:0]  rd0_idx;
   logic [1:0]  rd0_ew;
   logic [63:0] rd0_data;
   logic        rd0_err;
   logic [6:0]  rd1_base;
   logic [9:0]  rd1_idx;
   logic [1:0]  rd1_ew;
   logic [63:0] rd1_data;
   logic        rd1_err;

   int total = 0;
   int fails = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   elw_regfile u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_base(wr_base), .wr_idx(wr_idx),
      .wr_ew(wr_ew), .wr_data(wr_data), .wr_err(wr_err),
      .rd0_base(rd0_base), .rd0_idx(rd0_idx), .rd0_ew(rd0_ew), .rd0_data(rd0_data),
      .rd0_err(rd0_err), .rd1_base(rd1_base), .rd1_idx(rd1_idx), .rd1_ew(rd1_ew),
      .rd1_data(rd1_data), .rd1_err(rd1_err)
   );

   // {base, idx, ew, wdata, expected wr_err, check reg, expected check reg}
   localparam int NV = 14;
   localparam logic [154:0] VEC [NV] = '{
      {7'd1,   10'd0, 2'd1, 64'h0000_0000_FFFF_1111, 1'b0, 7'd1,   64'h0000_0000_0000_1111},
      {7'd1,   10'd1, 2'd1, 64'h0000_0000_0000_2222, 1'b0, 7'd1,   64'h0000_0000_2222_1111},
      {7'd1,   10'd2, 2'd1, 64'h0000_0000_0000_3333, 1'b0, 7'd1,   64'h0000_3333_2222_1111},
      {7'd1,   10'd3, 2'd1, 64'h0000_0000_0000_4444, 1'b0, 7'd1,   64'h4444_3333_2222_1111},
      {7'd1,   10'd4, 2'd1, 64'h0000_0000_0000_5555, 1'b0, 7'd2,   64'h0000_0000_0000_5555},
      {7'd2,   10'd5, 2'd0, 64'h0000_0000_0000_00AB, 1'b0, 7'd2,   64'h0000_AB00_0000_5555},
      {7'd0,   10'd5, 2'd2, 64'h0000_0000_DEAD_BEEF, 1'b0, 7'd2,   64'hDEAD_BEEF_0000_5555},
      {7'd3,   10'd0, 2'd3, 64'h0123_4567_89AB_CDEF, 1'b0, 7'd3,   64'h0123_4567_89AB_CDEF},
      {7'd3,   10'd7, 2'd0, 64'h0000_0000_0000_01FF, 1'b0, 7'd3,   64'hFF23_4567_89AB_CDEF},
      {7'd10,  10'd2, 2'd3, 64'h0000_0000_0000_CAFE, 1'b0, 7'd12,  64'h0000_0000_0000_CAFE},
      {7'd5,   10'd3, 2'd2, 64'h0000_0000_1122_3344, 1'b0, 7'd6,   64'h1122_3344_0000_0000},
      {7'd4,   10'd8, 2'd0, 64'h0000_0000_0000_005A, 1'b0, 7'd5,   64'h0000_0000_0000_005A},
      {7'd127, 10'd3, 2'd1, 64'h0000_0000_0000_7777, 1'b0, 7'd127, 64'h7777_0000_0000_0000},
      {7'd127, 10'd4, 2'd1, 64'h0000_0000_0000_8888, 1'b1, 7'd127, 64'h7777_0000_0000_0000}
   };

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      total++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_write(logic [6:0] b, logic [9:0] i, logic [1:0] e, logic [63:0] d,
                           output logic err);
      @(negedge clk);
      wr_base = b; wr_idx = i; wr_ew = e; wr_data = d; wr_en = 1'b1;
      #2 err = wr_err;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd0(logic [6:0] b, logic [9:0] i, logic [1:0] e);
      @(negedge clk);
      rd0_base = b; rd0_idx = i; rd0_ew = e;
      #2;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         total++; fails++;
         $display("FAIL watchdog expired");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      logic e;
      rst_n = 1'b0; wr_en = 1'b0; wr_base = '0; wr_idx = '0; wr_ew = '0; wr_data = '0;
      rd0_base = '0; rd0_idx = '0; rd0_ew = '0; rd1_base = '0; rd1_idx = '0; rd1_ew = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R8: storage cleared out of reset
      rd0(7'd3, 10'd0, 2'd3);
      chk("R8 reset reg3", rd0_data, 64'h0);
      chk("R8 reset err", {63'h0, rd0_err}, 64'h0);

      // R1 R2 R3 R4 R6: table of writes, each checked by reading a whole register
      for (int v = 0; v < NV; v++) begin
         logic [6:0] b; logic [9:0] i; logic [1:0] ew; logic [63:0] d;
         logic er; logic [6:0] cr; logic [63:0] cv;
         {b, i, ew, d, er, cr, cv} = VEC[v];
         do_write(b, i, ew, d, e);
         chk($sformatf("R6 wr_err vec %0d", v), {63'h0, e}, {63'h0, er});
         rd0(cr, 10'd0, 2'd3);
         chk($sformatf("R1 R2 R3 R4 data vec %0d", v), rd0_data, cv);
      end

      // R3: register 1 not touched by the element that spilled into register 2
      rd0(7'd1, 10'd0, 2'd3);
      chk("R3 reg1 intact", rd0_data, 64'h4444_3333_2222_1111);

      // R5 R9: both ports at once, right-aligned and zero-extended
      @(negedge clk);
      rd0_base = 7'd1; rd0_idx = 10'd2; rd0_ew = 2'd1;
      rd1_base = 7'd0; rd1_idx = 10'd13; rd1_ew = 2'd0;
      #2;
      chk("R5 R9 port0 half", rd0_data, 64'h3333);
      chk("R5 R9 port1 byte", rd1_data, 64'h33);
      rd0(7'd2, 10'd1, 2'd2);
      chk("R5 word", rd0_data, 64'hDEAD_BEEF);

      // R6: out-of-range read
      @(negedge clk);
      rd1_base = 7'd127; rd1_idx = 10'd1; rd1_ew = 2'd3;
      #2;
      chk("R6 rd err flag", {63'h0, rd1_err}, 64'h1);
      chk("R6 rd err data", rd1_data, 64'h0);

      // R7: read during write returns old, new after edge; port1 on other reg (R9)
      @(negedge clk);
      wr_base = 7'd1; wr_idx = 10'd0; wr_ew = 2'd1; wr_data = 64'h9999; wr_en = 1'b1;
      rd0_base = 7'd1; rd0_idx = 10'd0; rd0_ew = 2'd1;
      rd1_base = 7'd3; rd1_idx = 10'd0; rd1_ew = 2'd3;
      #2;
      chk("R7 old value", rd0_data, 64'h1111);
      @(negedge clk);
      wr_en = 1'b0;
      #2;
      chk("R7 new value", rd0_data, 64'h9999);
      chk("R9 R4 port1 other reg", rd1_data, 64'hFF23_4567_89AB_CDEF);

      // R8: reset in mid-run clears written registers
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      rd0(7'd3, 10'd0, 2'd3);
      chk("R8 reg3 cleared", rd0_data, 64'h0);
      rd0(7'd127, 10'd0, 2'd3);
      chk("R8 reg127 cleared", rd0_data, 64'h0);

      done = 1'b1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule